// File: doc/BRIEF.md
# Load/Store Effective Address and Lane Alignment Unit

This block sits between the integer register read stage and the data bus of a 32-bit load/store core whose data bus is 64 bits wide. For each access it forms the effective address, from either a base register plus a signed 16-bit displacement or a base register plus an index register. A base register field of zero selects the constant zero rather than the contents of register zero.

From the low address bits and the access width it derives the byte enables on the eight-byte bus and flags any access that would cross the eight-byte boundary. It places store data on the correct bus lanes and extracts and zero-extends load data from them, in either big-endian or little-endian byte order. For the update forms it produces the write-back of the effective address to the base register. It rejects the encodings in which that write-back would be meaningless.

All results appear one clock after a request is presented, qualified by a valid output. When no request was presented, every output is zero.

Top module: `lsu_agu`

## Requirements
- R1: With `use_index`=0 the effective address is base + sign-extended `disp`, where base is 0 when `base_sel`=0 and `base_val` otherwise; the sum wraps modulo 2^32.
- R2: With `use_index`=1 the effective address is base + `index_val`, with base formed as in R1.
- R3: The lane offset is address bits [2:0]. The width code is 2'b00 for one byte, 2'b01 for two bytes, and 2'b10 or 2'b11 for four bytes. For an access that fits within the eight bytes, `byte_en[k]` is 1 exactly for offset <= k < offset + width.
- R4: When offset + width > 8, `misalign`=1 and `byte_en`, `load_result` and `store_bus` are all zero.
- R5: With `little_end`=0, the byte at lane offset k sits on bus bits [63-8k:56-8k], and the most significant byte of a multibyte value sits at the lowest address.
- R6: With `little_end`=1, the byte at lane offset k sits on bus bits [8k+7:8k], and the least significant byte of a value sits at the lowest address.
- R7: `load_result` carries the addressed value in its low bits, and all bits above the access width are zero.
- R8: `store_bus` carries the low width bytes of `store_src` on the enabled lanes, and every other lane is zero.
- R9: When `update`=1 and the form is valid and aligned, `wb_en`=1 and `wb_value` equals the effective address.
- R10: An update with `base_sel`=0, or an update load (`is_store`=0) with `base_sel`=`dest_sel`, sets `bad_form`=1 and forces `wb_en`=0. An update store with `base_sel`=`dest_sel` is valid.
- R11: Outputs reflect the request presented on the previous clock edge, and `out_valid` follows `req_valid` by one cycle. When `out_valid`=0, and after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| base_sel | input | 5 | Base register field (0 selects constant zero) |
| base_val | input | 32 | Contents of the base register |
| index_val | input | 32 | Contents of the index register |
| disp | input | 16 | Signed displacement |
| use_index | input | 1 | 1: base+index, 0: base+displacement |
| size | input | 2 | Access width code |
| is_store | input | 1 | 1: store, 0: load |
| update | input | 1 | Write the address back to the base register |
| dest_sel | input | 5 | Destination register field of a load |
| little_end | input | 1 | Byte order select |
| store_src | input | 32 | Store source register contents |
| load_bus | input | 64 | Data returned from the bus for a load |
| out_valid | output | 1 | Results valid |
| eff_addr | output | 32 | Effective address |
| byte_en | output | 8 | Lane enables, bit k = address offset k |
| load_result | output | 32 | Zero-extended load value |
| store_bus | output | 64 | Lane-placed store data |
| wb_en | output | 1 | Base register write-back enable |
| wb_value | output | 32 | Value written back to the base register |
| bad_form | output | 1 | Invalid update encoding |
| misalign | output | 1 | Access crosses the eight-byte boundary |

## Verification
On every cycle the assertions check several properties: that the lane enable count matches the width code, that a boundary-crossing access mutes lanes and data, that byte loads are zero-extended, that write-back carries the address and never coexists with an invalid form, and that idle cycles stay quiet. The exact lane placement in each byte order, the sign extension of the displacement, and the zero-base substitution can only be shown by the bench. The bench compares every output each cycle against its byte-array model of memory, over directed corner cases and a long pseudo-random run.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;
   typedef enum logic [1:0] {
      ACC_BYTE  = 2'b00,
      ACC_HALF  = 2'b01,
      ACC_WORD  = 2'b10,
      ACC_WORD2 = 2'b11
   } acc_size_e;

   function automatic int unsigned acc_bytes(input logic [1:0] code, input int unsigned word_bytes);
      case (code)
         2'b00:   acc_bytes = 1;
         2'b01:   acc_bytes = 2;
         default: acc_bytes = word_bytes;
      endcase
   endfunction
endpackage

// File: rtl/lsu_agu_addr.sv
module lsu_agu_addr #(
   parameter int XLEN   = 32,
   parameter int DISP_W = 16,
   parameter int RIDX_W = 5
) (
   input  logic [RIDX_W-1:0] base_sel,
   input  logic [XLEN-1:0]   base_val,
   input  logic [XLEN-1:0]   index_val,
   input  logic [DISP_W-1:0] disp,
   input  logic              use_index,
   output logic [XLEN-1:0]   addr
);
   logic [XLEN-1:0] base_term;
   logic [XLEN-1:0] off_term;

   always_comb begin
      base_term = (base_sel == '0) ? '0 : base_val;
      off_term  = use_index ? index_val
                            : {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
      addr      = base_term + off_term;
   end
endmodule

// File: rtl/lsu_agu_lanes.sv
module lsu_agu_lanes #(
   parameter int BUS_BYTES = 8,
   localparam int OFF_W    = $clog2(BUS_BYTES),
   localparam int NB_W     = OFF_W + 1
) (
   input  logic [OFF_W-1:0]     offset,
   input  logic [NB_W-1:0]      nbytes,
   output logic [BUS_BYTES-1:0] lane_en,
   output logic                 crosses
);
   logic [NB_W-1:0] start_pos;
   logic [NB_W-1:0] end_pos;

   assign start_pos = {1'b0, offset};
   assign end_pos   = start_pos + nbytes;
   assign crosses   = end_pos > NB_W'(BUS_BYTES);

   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      assign lane_en[k] = (NB_W'(k) >= start_pos) && (NB_W'(k) < end_pos);
   end
endmodule

// File: rtl/lsu_agu_data.sv
module lsu_agu_data #(
   parameter int XLEN      = 32,
   parameter int BUS_BYTES = 8,
   localparam int BUS_W    = 8 * BUS_BYTES,
   localparam int OFF_W    = $clog2(BUS_BYTES),
   localparam int NB_W     = OFF_W + 1,
   localparam int WORD_B   = XLEN / 8
) (
   input  logic [OFF_W-1:0] offset,
   input  logic [NB_W-1:0]  nbytes,
   input  logic             little_end,
   input  logic [XLEN-1:0]  store_src,
   input  logic [BUS_W-1:0] load_bus,
   output logic [BUS_W-1:0] store_bus,
   output logic [XLEN-1:0]  load_result
);
   logic [NB_W-1:0]   shift_b;
   logic [NB_W+2:0]   shift_bits;
   logic [XLEN-1:0]   val_mask;

   always_comb begin
      // Big-endian puts the value's last byte at the highest lane, so the
      // shift is counted from the top of the bus; little-endian from lane 0.
      if (little_end) shift_b = {1'b0, offset};
      else            shift_b = NB_W'(BUS_BYTES) - {1'b0, offset} - nbytes;
      shift_bits  = {shift_b, 3'b000};
      val_mask    = (nbytes >= NB_W'(WORD_B)) ? '1
                                              : ~({XLEN{1'b1}} << {nbytes, 3'b000});
      store_bus   = BUS_W'(store_src & val_mask) << shift_bits;
      load_result = XLEN'(load_bus >> shift_bits) & val_mask;
   end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu #(
   parameter int XLEN      = 32,
   parameter int DISP_W    = 16,
   parameter int RIDX_W    = 5,
   parameter int BUS_BYTES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [RIDX_W-1:0]      base_sel,
   input  logic [XLEN-1:0]        base_val,
   input  logic [XLEN-1:0]        index_val,
   input  logic [DISP_W-1:0]      disp,
   input  logic                   use_index,
   input  logic [1:0]             size,
   input  logic                   is_store,
   input  logic                   update,
   input  logic [RIDX_W-1:0]      dest_sel,
   input  logic                   little_end,
   input  logic [XLEN-1:0]        store_src,
   input  logic [8*BUS_BYTES-1:0] load_bus,
   output logic                   out_valid,
   output logic [XLEN-1:0]        eff_addr,
   output logic [BUS_BYTES-1:0]   byte_en,
   output logic [XLEN-1:0]        load_result,
   output logic [8*BUS_BYTES-1:0] store_bus,
   output logic                   wb_en,
   output logic [XLEN-1:0]        wb_value,
   output logic                   bad_form,
   output logic                   misalign
);
   import lsu_agu_pkg::*;

   localparam int BUS_W  = 8 * BUS_BYTES;
   localparam int OFF_W  = $clog2(BUS_BYTES);
   localparam int NB_W   = OFF_W + 1;
   localparam int WORD_B = XLEN / 8;

   if (XLEN % 8 != 0 || XLEN < 16)
      $error("lsu_agu: XLEN must be a multiple of 8 and at least 16");
   if (BUS_BYTES < 2 || (BUS_BYTES & (BUS_BYTES - 1)) != 0)
      $error("lsu_agu: BUS_BYTES must be a power of two");
   if (BUS_BYTES < WORD_B)
      $error("lsu_agu: bus narrower than a word");
   if (DISP_W > XLEN || DISP_W < 1)
      $error("lsu_agu: DISP_W out of range");

   logic [XLEN-1:0]      addr_c;
   logic [NB_W-1:0]      nbytes_c;
   logic [BUS_BYTES-1:0] lanes_c;
   logic                 cross_c;
   logic [BUS_W-1:0]     st_c;
   logic [XLEN-1:0]      ld_c;
   logic                 bad_c;

   assign nbytes_c = NB_W'(acc_bytes(size, WORD_B));

   lsu_agu_addr #(.XLEN(XLEN), .DISP_W(DISP_W), .RIDX_W(RIDX_W)) i_addr (
      .base_sel (base_sel),
      .base_val (base_val),
      .index_val(index_val),
      .disp     (disp),
      .use_index(use_index),
      .addr     (addr_c)
   );

   lsu_agu_lanes #(.BUS_BYTES(BUS_BYTES)) i_lanes (
      .offset (addr_c[OFF_W-1:0]),
      .nbytes (nbytes_c),
      .lane_en(lanes_c),
      .crosses(cross_c)
   );

   lsu_agu_data #(.XLEN(XLEN), .BUS_BYTES(BUS_BYTES)) i_data (
      .offset     (addr_c[OFF_W-1:0]),
      .nbytes     (nbytes_c),
      .little_end (little_end),
      .store_src  (store_src),
      .load_bus   (load_bus),
      .store_bus  (st_c),
      .load_result(ld_c)
   );

   assign bad_c = update && ((base_sel == '0) || (!is_store && (base_sel == dest_sel)));

   always_ff @(posedge clk) begin
      if (!rst_n || !req_valid) begin
         out_valid   <= 1'b0;
         eff_addr    <= '0;
         byte_en     <= '0;
         load_result <= '0;
         store_bus   <= '0;
         wb_en       <= 1'b0;
         wb_value    <= '0;
         bad_form    <= 1'b0;
         misalign    <= 1'b0;
      end else begin
         out_valid   <= 1'b1;
         eff_addr    <= addr_c;
         byte_en     <= cross_c ? '0 : lanes_c;
         load_result <= cross_c ? '0 : ld_c;
         store_bus   <= cross_c ? '0 : st_c;
         wb_en       <= update && !bad_c && !cross_c;
         wb_value    <= (update && !bad_c && !cross_c) ? addr_c : '0;
         bad_form    <= bad_c;
         misalign    <= cross_c;
      end
   end
endmodule

// File: rtl/lsu_agu_chk.sv
module lsu_agu_chk #(
   parameter int XLEN      = 32,
   parameter int BUS_BYTES = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic [1:0]             size,
   input logic                   out_valid,
   input logic [XLEN-1:0]        eff_addr,
   input logic [BUS_BYTES-1:0]   byte_en,
   input logic [XLEN-1:0]        load_result,
   input logic [8*BUS_BYTES-1:0] store_bus,
   input logic                   wb_en,
   input logic [XLEN-1:0]        wb_value,
   input logic                   bad_form,
   input logic                   misalign
);
   localparam int WORD_B = XLEN / 8;

   // R11
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (byte_en == '0 && !wb_en && !bad_form && !misalign && store_bus == '0));

   // R4
   cross_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && misalign) |-> (byte_en == '0 && store_bus == '0 && load_result == '0));

   // R3
   lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !misalign) |->
         ($countones(byte_en) == (($past(size) == 2'b00) ? 1 : ($past(size) == 2'b01) ? 2 : WORD_B)));

   // R7
   byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(size) == 2'b00) |-> (load_result[XLEN-1:8] == '0));

   // R9
   wb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_value == eff_addr && !bad_form && !misalign));

   // R10
   bad_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_form |-> !wb_en);
endmodule

bind lsu_agu lsu_agu_chk #(.XLEN(XLEN), .BUS_BYTES(BUS_BYTES)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .size       (size),
   .out_valid  (out_valid),
   .eff_addr   (eff_addr),
   .byte_en    (byte_en),
   .load_result(load_result),
   .store_bus  (store_bus),
   .wb_en      (wb_en),
   .wb_value   (wb_value),
   .bad_form   (bad_form),
   .misalign   (misalign)
);

// File: tb/test_lsu_agu.sv
module test_lsu_agu;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [4:0]  base_sel, dest_sel;
   logic [31:0] base_val, index_val, store_src;
   logic [15:0] disp;
   logic        use_index, is_store, update, little_end;
   logic [1:0]  size;
   logic [63:0] load_bus;
   logic        out_valid, wb_en, bad_form, misalign;
   logic [31:0] eff_addr, load_result, wb_value;
   logic [7:0]  byte_en;
   logic [63:0] store_bus;

   int checks = 0;
   int failures = 0;

   // expected outputs for the request driven last
   logic        e_valid, e_wb, e_bad, e_mis;
   logic [31:0] e_addr, e_ld, e_wbv;
   logic [7:0]  e_be;
   logic [63:0] e_st;
   string       e_atag, e_dtag;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsu_agu i_lsu_agu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_sel(base_sel),
      .base_val(base_val), .index_val(index_val), .disp(disp), .use_index(use_index),
      .size(size), .is_store(is_store), .update(update), .dest_sel(dest_sel),
      .little_end(little_end), .store_src(store_src), .load_bus(load_bus),
      .out_valid(out_valid), .eff_addr(eff_addr), .byte_en(byte_en),
      .load_result(load_result), .store_bus(store_bus), .wb_en(wb_en),
      .wb_value(wb_value), .bad_form(bad_form), .misalign(misalign)
   );

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R11 out_valid", 64'(out_valid), 64'(e_valid));
      chk(e_atag, 64'(eff_addr), 64'(e_addr));
      chk(e_mis ? "R4 byte_en" : "R3 byte_en", 64'(byte_en), 64'(e_be));
      chk(e_mis ? "R4 misalign" : "R3 misalign", 64'(misalign), 64'(e_mis));
      chk({e_dtag, " R7 load_result"}, 64'(load_result), 64'(e_ld));
      chk({e_dtag, " R8 store_bus"}, store_bus, e_st);
      chk(e_bad ? "R10 wb_en" : "R9 wb_en", 64'(wb_en), 64'(e_wb));
      chk("R9 wb_value", 64'(wb_value), 64'(e_wbv));
      chk("R10 bad_form", 64'(bad_form), 64'(e_bad));
   endtask

   // Behavioural model: memory bytes of one doubleword, placed per byte order.
   task automatic model();
      logic [7:0]  mem [8];
      logic [31:0] base, off;
      int n, o;
      e_valid = req_valid; e_addr = '0; e_be = '0; e_ld = '0; e_st = '0;
      e_wb = 1'b0; e_wbv = '0; e_bad = 1'b0; e_mis = 1'b0;
      e_atag = "R11 eff_addr"; e_dtag = "R11";
      if (!req_valid) return;
      base = (base_sel == 0) ? 32'd0 : base_val;
      off  = use_index ? index_val : {{16{disp[15]}}, disp};
      e_addr = base + off;
      e_atag = use_index ? "R2 eff_addr" : "R1 eff_addr";
      e_dtag = little_end ? "R6" : "R5";
      n = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
      o = int'(e_addr[2:0]);
      e_mis = (o + n) > 8;
      e_bad = update && (base_sel == 0 || (!is_store && base_sel == dest_sel));
      e_wb  = update && !e_bad && !e_mis;
      e_wbv = e_wb ? e_addr : 32'd0;
      if (e_mis) return;
      for (int k = 0; k < 8; k++) begin
         e_be[k] = (k >= o) && (k < o + n);
         mem[k]  = little_end ? load_bus[8*k +: 8] : load_bus[56-8*k +: 8];
      end
      for (int i = 0; i < n; i++) begin
         if (little_end) e_ld[8*i +: 8] = mem[o+i];
         else            e_ld[8*(n-1-i) +: 8] = mem[o+i];
      end
      for (int k = 0; k < 8; k++) mem[k] = 8'h00;
      for (int i = 0; i < n; i++)
         mem[o+i] = little_end ? store_src[8*i +: 8] : store_src[8*(n-1-i) +: 8];
      for (int k = 0; k < 8; k++) begin
         if (little_end) e_st[8*k +: 8] = mem[k];
         else            e_st[56-8*k +: 8] = mem[k];
      end
   endtask

   task automatic step(input logic v, input logic [4:0] bs, input logic [31:0] bv,
                       input logic [31:0] iv, input logic [15:0] d, input logic ui,
                       input logic [1:0] sz, input logic st, input logic up,
                       input logic [4:0] ds, input logic le, input logic [31:0] src,
                       input logic [63:0] lb);
      @(negedge clk);
      compare_all();
      req_valid = v; base_sel = bs; base_val = bv; index_val = iv; disp = d;
      use_index = ui; size = sz; is_store = st; update = up; dest_sel = ds;
      little_end = le; store_src = src; load_bus = lb;
      model();
   endtask

   localparam logic [63:0] PAT = 64'h1122_3344_5566_7788;

   initial begin
      rst_n = 1'b0;
      req_valid = 0; base_sel = 0; base_val = 0; index_val = 0; disp = 0;
      use_index = 0; size = 0; is_store = 0; update = 0; dest_sel = 0;
      little_end = 0; store_src = 0; load_bus = 0;
      model();
      repeat (3) @(negedge clk);
      // R11 reset state
      compare_all();
      rst_n = 1'b1;
      // R1 negative displacement, R5 big-endian word load at offset 4
      step(1, 5'd3, 32'h0000_1000, 0, 16'hFFFC, 0, 2'b10, 0, 0, 5'd1, 0, 0, PAT);
      // R1 zero base field selects 0
      step(1, 5'd0, 32'hDEAD_BEEF, 0, 16'h0014, 0, 2'b00, 0, 0, 5'd1, 0, 0, PAT);
      // R2 index mode, zero base
      step(1, 5'd0, 32'hFFFF_FFFF, 32'h0000_0207, 16'h0, 1, 2'b00, 0, 0, 5'd2, 1, 0, PAT);
      // R6 little-endian halfword load, offset 2
      step(1, 5'd4, 32'h100, 32'h2, 16'h0, 1, 2'b01, 0, 0, 5'd2, 1, 0, PAT);
      // R8 R5 halfword store, big-endian, offset 6
      step(1, 5'd4, 32'h106, 0, 16'h0, 0, 2'b01, 1, 0, 5'd2, 0, 32'hAABB_CCDD, 0);
      // R4 word at offset 6 crosses
      step(1, 5'd4, 32'h106, 0, 16'h0, 0, 2'b10, 0, 1, 5'd2, 0, 0, PAT);
      // R4 halfword at offset 7 crosses
      step(1, 5'd4, 32'h0, 0, 16'h7, 0, 2'b01, 1, 0, 5'd2, 1, 32'h1234, 0);
      // idle cycle
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      // R9 valid update load
      step(1, 5'd7, 32'h2000, 0, 16'h0010, 0, 2'b10, 0, 1, 5'd8, 0, 0, PAT);
      // R10 update with zero base field
      step(1, 5'd0, 32'h2000, 0, 16'h0010, 0, 2'b10, 0, 1, 5'd8, 0, 0, PAT);
      // R10 update load with base == dest
      step(1, 5'd9, 32'h3000, 0, 16'h0008, 0, 2'b00, 0, 1, 5'd9, 0, 0, PAT);
      // R10 update store with base == dest is valid
      step(1, 5'd9, 32'h3000, 32'h4, 16'h0, 1, 2'b10, 1, 1, 5'd9, 1, 32'hCAFE_F00D, 0);
      // R1 wrap around
      step(1, 5'd5, 32'hFFFF_FFFE, 0, 16'h0003, 0, 2'b00, 0, 0, 5'd1, 0, 0, PAT);
      // R3 every offset, every width, both orders
      for (int le = 0; le < 2; le++)
         for (int sz = 0; sz < 4; sz++)
            for (int o = 0; o < 8; o++)
               step(1, 5'd6, 32'h4000 + o, 0, 0, 0, 2'(sz), (o % 2) == 1, 0, 5'd1,
                    1'(le), 32'h8899_AABB + o, PAT ^ {8{8'(o)}});
      // pseudo-random mix
      for (int i = 0; i < 600; i++)
         step(($urandom % 5) != 0, 5'($urandom % 4), $urandom, $urandom,
              16'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
              1'($urandom), 5'($urandom % 4), 1'($urandom), $urandom,
              {$urandom, $urandom});
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      summary();
      $finish;
   end
endmodule